// File: doc/BRIEF.md
# Paper Tape Reader and Punch Controller

This block sits between a processor's command port and two paper tape mechanisms, a tape reader and a tape punch. The processor sends short commands: punch a character, move the reader one character, fetch the last character read, or read the status word with or without clearing it. Each device is driven through its own four-phase request/acknowledge handshake. The mechanism's motors and timing are handled on the far side of that handshake.

The punch channel latches the processor's character and presents it with a request until the punch acknowledges. The reader channel raises a request, takes the channel bits that arrive with the acknowledge, and holds them until the processor fetches them. Both channels run at the same time without affecting each other. Each channel reports busy, complete and not-ready in a status word and raises its own interrupt when an operation completes. A device that reports not ready ignores the commands sent to it.

Top module: `ptape_ctrl`

## Requirements
- R1: After reset, `pun_req`, `rdr_req`, `irq_punch`, `irq_reader`, `rsp_valid` and `rsp_data` are all low.
- R2: A command with `cmd_op`=1 (punch) sent while the punch is idle and ready raises `pun_req` on the next clock, with `pun_data` equal to `cmd_wdata`. Both hold steady until `pun_ack` is seen high.
- R3: On either channel, the request falls on the clock after its acknowledge is seen high. No new request starts while that acknowledge is still high.
- R4: A command with `cmd_op`=2 (feed) raises `rdr_req`. The reader captures `rdr_data` on the clock at which `rdr_ack` is seen high. A later command with `cmd_op`=3 (fetch) returns that character on `rsp_data`.
- R5: A fetch issued before any character has been captured returns zero.
- R6: While a device's not-ready input is high, commands to that device start no request and do not set its busy bit.
- R7: The status word has these bits: bit0 punch busy, bit1 punch complete, bit2 punch not ready, bit3 reader busy, bit4 reader complete, bit5 reader not ready. Higher bits are zero. A busy bit is high from the clock that starts a request until the clock at which that channel's acknowledge is seen low again.
- R8: A complete bit and its interrupt output (`irq_punch` or `irq_reader`) go high on the clock at which the acknowledge is seen low. A status read with `cmd_op`=4 leaves them set. A status read with `cmd_op`=5 returns the word as it was, then clears both complete bits.
- R9: The two channels are independent. A reader operation can start and complete while a punch request stays pending, and the reverse also holds.
- R10: A punch command received while the punch is busy is ignored: `pun_data` keeps its value and no request is added.
- R11: `rsp_valid` is high for exactly the clock after a fetch or status command, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one clock per command |
| cmd_op | input | 3 | 1 punch, 2 feed, 3 fetch, 4 status, 5 status and clear |
| cmd_wdata | input | CHAR_W | Character for a punch command |
| rsp_valid | output | 1 | Response data valid |
| rsp_data | output | CHAR_W | Fetched character or status word |
| irq_punch | output | 1 | Punch operation complete |
| irq_reader | output | 1 | Reader operation complete |
| pun_req | output | 1 | Punch request |
| pun_data | output | CHAR_W | Character to punch |
| pun_ack | input | 1 | Punch acknowledge |
| pun_nrdy | input | 1 | Punch not ready |
| rdr_req | output | 1 | Reader move request |
| rdr_ack | input | 1 | Reader acknowledge, data valid |
| rdr_data | input | CHAR_W | Channel bits from the reader |
| rdr_nrdy | input | 1 | Reader not ready |

## Verification
The bench builds the block with the default CHAR_W of 8. At this width every channel pattern of a tape character can be punched and read back, including all-ones and alternating bits. It also leaves room for the six status bits plus two bits that must read zero. At this width the status word and the fetched character share one response bus, so a wrong select between the two shows up directly in the value returned. A table of character pairs drives both channels at once through busy, acknowledge and completion phases. Directed cases then cover not-ready, a long-held request, and a reader that completes while the punch waits.

// File: rtl/ptape_pkg.sv
package ptape_pkg;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_PUNCH     = 3'd1,
        OP_FEED      = 3'd2,
        OP_FETCH     = 3'd3,
        OP_STATUS    = 3'd4,
        OP_STATUS_CLR = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_REQ  = 2'd1,
        HS_REL  = 2'd2
    } hs_state_e;

    // Packed MSB first: bit0 is punch busy, bit5 is reader not ready.
    typedef struct packed {
        logic rdr_nrdy;
        logic rdr_done;
        logic rdr_busy;
        logic pun_nrdy;
        logic pun_done;
        logic pun_busy;
    } status_t;

    localparam int STATUS_W = $bits(status_t);
    localparam int NUM_CHAN = 2;

    function automatic logic hs_can_start(hs_state_e st, logic nrdy, logic ack);
        return (st == HS_IDLE) && !nrdy && !ack;
    endfunction

endpackage

// File: rtl/ptape_hs_chan.sv
module ptape_hs_chan
    import ptape_pkg::*;
#(
    parameter int CHAR_W     = 8,
    parameter bit CAPTURE_IN = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dev_nrdy,
    input  logic              dev_ack,
    input  logic [CHAR_W-1:0] cmd_char,
    input  logic [CHAR_W-1:0] dev_char,
    output logic              dev_req,
    output logic [CHAR_W-1:0] char_q,
    output logic              busy,
    output logic              done
);

    hs_state_e   st;
    logic        accept;
    logic        load_en;
    logic [CHAR_W-1:0] load_val;

    assign accept = start && hs_can_start(st, dev_nrdy, dev_ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= HS_IDLE;
        end else begin
            unique case (st)
                HS_IDLE: if (accept)   st <= HS_REQ;
                HS_REQ:  if (dev_ack)  st <= HS_REL;
                HS_REL:  if (!dev_ack) st <= HS_IDLE;
                default:               st <= HS_IDLE;
            endcase
        end
    end

    assign dev_req = (st == HS_REQ);
    assign busy    = (st != HS_IDLE);
    assign done    = (st == HS_REL) && !dev_ack;

    // Reader variant samples the device bits at acknowledge;
    // punch variant latches the processor character at start.
    generate
        if (CAPTURE_IN) begin : g_capture
            assign load_en  = (st == HS_REQ) && dev_ack;
            assign load_val = dev_char | (cmd_char & '0);
        end else begin : g_drive
            assign load_en  = accept;
            assign load_val = cmd_char | (dev_char & '0);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            char_q <= '0;
        end else if (load_en) begin
            char_q <= load_val;
        end
    end

endmodule

// File: rtl/ptape_status.sv
module ptape_status
    import ptape_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pun_busy,
    input  logic    pun_done,
    input  logic    pun_nrdy,
    input  logic    rdr_busy,
    input  logic    rdr_done,
    input  logic    rdr_nrdy,
    input  logic    clr_done,
    output status_t status,
    output logic    irq_punch,
    output logic    irq_reader
);

    logic [NUM_CHAN-1:0] done_set;
    logic [NUM_CHAN-1:0] done_q;

    assign done_set = {rdr_done, pun_done};

    generate
        for (genvar i = 0; i < NUM_CHAN; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst) begin
                    done_q[i] <= 1'b0;
                end else if (done_set[i]) begin
                    done_q[i] <= 1'b1;
                end else if (clr_done) begin
                    done_q[i] <= 1'b0;
                end
            end
        end
    endgenerate

    always_comb begin
        status          = '0;
        status.pun_busy = pun_busy;
        status.pun_done = done_q[0];
        status.pun_nrdy = pun_nrdy;
        status.rdr_busy = rdr_busy;
        status.rdr_done = done_q[1];
        status.rdr_nrdy = rdr_nrdy;
    end

    assign irq_punch  = done_q[0];
    assign irq_reader = done_q[1];

endmodule

// File: rtl/ptape_ctrl.sv
module ptape_ctrl
    import ptape_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [CHAR_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [CHAR_W-1:0] rsp_data,
    output logic              irq_punch,
    output logic              irq_reader,
    output logic              pun_req,
    output logic [CHAR_W-1:0] pun_data,
    input  logic              pun_ack,
    input  logic              pun_nrdy,
    output logic              rdr_req,
    input  logic              rdr_ack,
    input  logic [CHAR_W-1:0] rdr_data,
    input  logic              rdr_nrdy
);

    op_e     op;
    logic    go_punch, go_feed, do_fetch, do_status, do_clr;
    logic    pun_busy, pun_done, rdr_busy, rdr_done;
    logic [CHAR_W-1:0] rdr_char;
    status_t status;

    assign op        = op_e'(cmd_op);
    assign go_punch  = cmd_valid && (op == OP_PUNCH);
    assign go_feed   = cmd_valid && (op == OP_FEED);
    assign do_fetch  = cmd_valid && (op == OP_FETCH);
    assign do_clr    = cmd_valid && (op == OP_STATUS_CLR);
    assign do_status = cmd_valid && ((op == OP_STATUS) || (op == OP_STATUS_CLR));

    ptape_hs_chan #(.CHAR_W(CHAR_W), .CAPTURE_IN(1'b0)) u_punch (
        .clk      (clk),
        .rst      (rst),
        .start    (go_punch),
        .dev_nrdy (pun_nrdy),
        .dev_ack  (pun_ack),
        .cmd_char (cmd_wdata),
        .dev_char ('0),
        .dev_req  (pun_req),
        .char_q   (pun_data),
        .busy     (pun_busy),
        .done     (pun_done)
    );

    ptape_hs_chan #(.CHAR_W(CHAR_W), .CAPTURE_IN(1'b1)) u_reader (
        .clk      (clk),
        .rst      (rst),
        .start    (go_feed),
        .dev_nrdy (rdr_nrdy),
        .dev_ack  (rdr_ack),
        .cmd_char ('0),
        .dev_char (rdr_data),
        .dev_req  (rdr_req),
        .char_q   (rdr_char),
        .busy     (rdr_busy),
        .done     (rdr_done)
    );

    ptape_status u_status (
        .clk        (clk),
        .rst        (rst),
        .pun_busy   (pun_busy),
        .pun_done   (pun_done),
        .pun_nrdy   (pun_nrdy),
        .rdr_busy   (rdr_busy),
        .rdr_done   (rdr_done),
        .rdr_nrdy   (rdr_nrdy),
        .clr_done   (do_clr),
        .status     (status),
        .irq_punch  (irq_punch),
        .irq_reader (irq_reader)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= do_fetch || do_status;
            if (do_fetch) begin
                rsp_data <= rdr_char;
            end else if (do_status) begin
                rsp_data <= CHAR_W'(status);
            end
        end
    end

endmodule

// File: rtl/ptape_ctrl_chk.sv
module ptape_ctrl_chk #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              rsp_valid,
    input logic              pun_req,
    input logic [CHAR_W-1:0] pun_data,
    input logic              pun_ack,
    input logic              pun_nrdy,
    input logic              rdr_req,
    input logic              rdr_ack,
    input logic              rdr_nrdy
);

    a_r2_punch_hold: assert property (@(posedge clk) disable iff (rst)
        (pun_req && !pun_ack) |=> pun_req);

    a_r2_punch_data_steady: assert property (@(posedge clk) disable iff (rst)
        (pun_req && $past(pun_req)) |-> $stable(pun_data));

    a_r3_punch_drop: assert property (@(posedge clk) disable iff (rst)
        (pun_req && pun_ack) |=> !pun_req);

    a_r3_punch_no_restart: assert property (@(posedge clk) disable iff (rst)
        (!pun_req && pun_ack) |=> !pun_req);

    a_r3_reader_drop: assert property (@(posedge clk) disable iff (rst)
        (rdr_req && rdr_ack) |=> !rdr_req);

    a_r3_reader_no_restart: assert property (@(posedge clk) disable iff (rst)
        (!rdr_req && rdr_ack) |=> !rdr_req);

    a_r4_reader_hold: assert property (@(posedge clk) disable iff (rst)
        (rdr_req && !rdr_ack) |=> rdr_req);

    a_r6_punch_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(pun_req) |-> $past(!pun_nrdy));

    a_r6_reader_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(rdr_req) |-> $past(!rdr_nrdy));

    a_r11_rsp_after_cmd: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(cmd_valid));

endmodule

bind ptape_ctrl ptape_ctrl_chk #(.CHAR_W(CHAR_W)) u_chk (.*);

// File: tb/tb_ptape_ctrl.sv
module tb_ptape_ctrl;

    localparam int CHAR_W = 8;
    localparam int NVEC   = 4;

    // {punch char, reader char}
    localparam logic [15:0] VEC [NVEC] = '{16'hA5_3C, 16'hFF_00, 16'h01_80, 16'h5A_FF};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = 3'd0;
    logic [CHAR_W-1:0] cmd_wdata = '0;
    logic              rsp_valid;
    logic [CHAR_W-1:0] rsp_data;
    logic              irq_punch, irq_reader;
    logic              pun_req;
    logic [CHAR_W-1:0] pun_data;
    logic              pun_ack = 1'b0;
    logic              pun_nrdy = 1'b0;
    logic              rdr_req;
    logic              rdr_ack = 1'b0;
    logic [CHAR_W-1:0] rdr_data = '0;
    logic              rdr_nrdy = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    ptape_ctrl #(.CHAR_W(CHAR_W)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .irq_punch(irq_punch), .irq_reader(irq_reader),
        .pun_req(pun_req), .pun_data(pun_data), .pun_ack(pun_ack),
        .pun_nrdy(pun_nrdy), .rdr_req(rdr_req), .rdr_ack(rdr_ack),
        .rdr_data(rdr_data), .rdr_nrdy(rdr_nrdy)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [CHAR_W-1:0] d);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
    endtask

    task automatic status_is(input logic [CHAR_W-1:0] exp, input string req);
        issue(3'd4, '0);
        check(rsp_valid && rsp_data == exp, req, int'(rsp_data), int'(exp));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(!pun_req && !rdr_req, "R1 requests", {pun_req, rdr_req}, 0);
        check(!irq_punch && !irq_reader, "R1 irqs", {irq_punch, irq_reader}, 0);
        check(!rsp_valid && rsp_data == '0, "R1 response", int'(rsp_data), 0);
        // R5 fetch before any capture
        issue(3'd3, '0);
        check(rsp_valid && rsp_data == '0, "R5 empty fetch", int'(rsp_data), 0);
        @(negedge clk);
        check(!rsp_valid, "R11 valid one clock", rsp_valid, 0);
        status_is(8'h00, "R7 idle status");

        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] pc, rc;
            pc = VEC[v][15:8];
            rc = VEC[v][7:0];
            issue(3'd1, pc);
            check(pun_req && pun_data == pc, "R2 punch request", int'(pun_data), int'(pc));
            issue(3'd2, '0);
            check(rdr_req && pun_req, "R9 both requests", {rdr_req, pun_req}, 3);
            status_is(8'h09, "R7 both busy");
            pun_ack  = 1'b1;
            rdr_ack  = 1'b1;
            rdr_data = rc;
            @(negedge clk);
            rdr_data = ~rc;
            check(!pun_req && !rdr_req, "R3 requests drop", {pun_req, rdr_req}, 0);
            status_is(8'h09, "R7 busy until ack low");
            issue(3'd1, ~pc);
            check(!pun_req && pun_data == pc, "R10 busy punch ignored", int'(pun_data), int'(pc));
            pun_ack = 1'b0;
            rdr_ack = 1'b0;
            @(negedge clk);
            check(irq_punch && irq_reader, "R8 irqs on completion", {irq_punch, irq_reader}, 3);
            status_is(8'h12, "R8 complete bits");
            status_is(8'h12, "R8 status keeps bits");
            issue(3'd5, '0);
            check(rsp_data == 8'h12, "R8 clear returns old", int'(rsp_data), 'h12);
            check(!irq_punch && !irq_reader, "R8 irqs cleared", {irq_punch, irq_reader}, 0);
            issue(3'd3, '0);
            check(rsp_valid && rsp_data == rc, "R4 fetch char", int'(rsp_data), int'(rc));
        end

        // R2 request held while waiting
        issue(3'd1, 8'h6E);
        repeat (5) @(negedge clk);
        check(pun_req && pun_data == 8'h6E, "R2 long hold", int'(pun_data), 'h6E);
        // R9 reader completes while punch waits
        issue(3'd2, '0);
        rdr_ack = 1'b1; rdr_data = 8'hC3;
        @(negedge clk);
        rdr_ack = 1'b0;
        @(negedge clk);
        check(pun_req && irq_reader && !irq_punch, "R9 reader alone done",
              {pun_req, irq_reader, irq_punch}, 6);
        issue(3'd3, '0);
        check(rsp_data == 8'hC3, "R9 reader char", int'(rsp_data), 'hC3);
        pun_ack = 1'b1;
        @(negedge clk);
        pun_ack = 1'b0;
        @(negedge clk);
        issue(3'd5, '0);
        check(rsp_data == 8'h12, "R9 punch done later", int'(rsp_data), 'h12);

        // R6 not ready
        pun_nrdy = 1'b1;
        status_is(8'h04, "R7 punch not ready bit");
        issue(3'd1, 8'h11);
        check(!pun_req && pun_data == 8'h6E, "R6 punch ignored", int'(pun_data), 'h6E);
        status_is(8'h04, "R6 punch not busy");
        rdr_nrdy = 1'b1;
        issue(3'd2, '0);
        check(!rdr_req, "R6 reader ignored", rdr_req, 0);
        status_is(8'h24, "R6 reader not busy");
        pun_nrdy = 1'b0;
        rdr_nrdy = 1'b0;
        issue(3'd1, 8'h11);
        check(pun_req && pun_data == 8'h11, "R6 ready again", int'(pun_data), 'h11);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule